// File: doc/BRIEF.md
# Split-Half Alternating Read Speed Tester

This controller checks whether a word-wide RAM still returns correct data when reads arrive close together. A pass has two phases. First it writes every location in ascending address order. Locations whose top address bit is 0 receive an all-zero word, and locations whose top address bit is 1 receive an all-one word. Then it reads every location back. The reads alternate between the lower and upper halves, so each read flips the most significant address bit and the expected word. A pass ends at the first mismatch or after the last read. At that point the controller raises a done level and, on a mismatch, a fail level.

Between one read completing and the next read being issued, the controller idles for a programmable number of cycles. Each pass that succeeds lowers this count by one for the next pass. A sweep of repeated starts therefore tightens the read spacing until the memory breaks. The controller holds the count of the most recent passing pass as the characterized spacing. The memory may take any number of cycles to answer a read, and only one read is outstanding at a time.

Top module: `split_speed_tester`

## Requirements
- R1: After reset, done, fail, mem_we, mem_re and best_valid are all 0.
- R2: After an accepted start, the controller writes on N = 2^ADDR_W consecutive cycles to addresses 0 through N-1 in ascending order. The write data is all zeros when address bit ADDR_W-1 is 0 and all ones when it is 1.
- R3: The read phase issues reads to addresses in the order 0, N/2, 1, N/2+1, ..., N/2-1, N-1. Each read after the first in a pass has its top address bit inverted relative to the previous read.
- R4: No read is issued while an earlier read is still outstanding, meaning before mem_rvalid has returned. The gap between the mem_rvalid cycle and the next mem_re cycle is exactly the pass's wait count, in idle cycles.
- R5: When read data differs from the expected word, the pass stops with no further accesses. fail rises together with done, and fail_addr holds the address of the failing read. A mismatch on the last read of a pass is reported as a failure.
- R6: A pass with no mismatch ends with done=1 and fail=0. It sets best_valid=1 and makes best_wait the wait count that pass used.
- R7: The start after a passing pass uses that pass's wait count minus one, and the count stays at 0 once it reaches 0.
- R8: The first start after reset, and the first start after a failing pass, load the wait count from wait_init and clear best_valid. A failing pass leaves best_wait and best_valid unchanged.
- R9: A start pulse during a pass (done=0) is ignored. The pass runs to its normal end, and the wait count sequence is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass when idle or done |
| wait_init | input | CNT_W | Initial idle-cycle count for a fresh sweep |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| done | output | 1 | Pass finished (level until next start) |
| fail | output | 1 | Pass finished with a mismatch |
| fail_addr | output | ADDR_W | Address of the failing read |
| best_wait | output | CNT_W | Wait count of the latest passing pass |
| best_valid | output | 1 | best_wait holds a result of the current sweep |

## Verification
Two events can fall on the same completion cycle: the mismatch verdict and the last-read detection that normally closes a pass as a success. The bench provokes this by having its memory model corrupt only address N-1, which is the final read of the order. It then requires fail=1 with fail_addr=N-1 and an unchanged best_valid. A second overlap occurs when a busy start coincides with the write phase. This is judged by requiring the following pass to use exactly one less idle cycle.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FILL,
        SQ_ISSUE,
        SQ_AWAIT,
        SQ_GAP,
        SQ_END
    } sq_state_e;

    typedef struct packed {
        logic got;
        logic bad;
        logic last;
    } rd_event_t;

endpackage

// File: rtl/walk_counter.sv
module walk_counter #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] idx,
    output logic              at_last
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    assign at_last = &idx;
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt <= CNT_W'(1));
endmodule

// File: rtl/word_check.sv
module word_check #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic              upper,
    output logic              mismatch
);
    logic [DATA_W-1:0] diff;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign diff[b] = word[b] ^ upper;
    end

    assign mismatch = |diff;
endmodule

// File: rtl/split_speed_tester.sv
module split_speed_tester
    import mtest_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  wait_init,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [CNT_W-1:0]  best_wait,
    output logic              best_valid
);
    localparam int TOP = ADDR_W - 1;

    sq_state_e         state;
    logic [CNT_W-1:0]  cur_wait;
    logic              fresh;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] rd_addr;
    logic              at_last;
    logic              accept;
    logic              idx_clear;
    logic              idx_step;
    logic              tmr_load;
    logic              tmr_last;
    logic              mismatch;
    rd_event_t         ev;

    // Read order: low index bit picks the half, the rest walks within it.
    assign rd_addr = {idx[0], idx[TOP:1]};

    assign accept  = start && (state == SQ_IDLE || state == SQ_END);

    assign ev.got  = (state == SQ_AWAIT) && mem_rvalid;
    assign ev.bad  = mismatch;
    assign ev.last = at_last;

    assign idx_clear = accept || (state == SQ_FILL && at_last);
    assign idx_step  = (state == SQ_FILL) || (ev.got && !ev.bad && !ev.last);
    assign tmr_load  = ev.got && !ev.bad && !ev.last;

    walk_counter #(.ADDR_W(ADDR_W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .clear   (idx_clear),
        .step    (idx_step),
        .idx     (idx),
        .at_last (at_last)
    );

    gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (cur_wait),
        .tick     (state == SQ_GAP),
        .last     (tmr_last)
    );

    word_check #(.DATA_W(DATA_W)) u_cmp (
        .word     (mem_rdata),
        .upper    (rd_addr[TOP]),
        .mismatch (mismatch)
    );

    assign mem_we    = (state == SQ_FILL);
    assign mem_re    = (state == SQ_ISSUE);
    assign mem_addr  = (state == SQ_FILL) ? idx : rd_addr;
    assign mem_wdata = {DATA_W{idx[TOP]}};
    assign done      = (state == SQ_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            cur_wait   <= '0;
            fresh      <= 1'b1;
            best_wait  <= '0;
            best_valid <= 1'b0;
            fail       <= 1'b0;
            fail_addr  <= '0;
        end else begin
            case (state)
                SQ_IDLE, SQ_END: begin
                    if (accept) begin
                        state <= SQ_FILL;
                        fail  <= 1'b0;
                        if (fresh) begin
                            cur_wait   <= wait_init;
                            best_valid <= 1'b0;
                        end
                    end
                end
                SQ_FILL: begin
                    if (at_last) state <= SQ_ISSUE;
                end
                SQ_ISSUE: begin
                    state <= SQ_AWAIT;
                end
                SQ_AWAIT: begin
                    if (ev.got) begin
                        if (ev.bad) begin
                            fail      <= 1'b1;
                            fail_addr <= rd_addr;
                            fresh     <= 1'b1;
                            state     <= SQ_END;
                        end else if (ev.last) begin
                            best_wait  <= cur_wait;
                            best_valid <= 1'b1;
                            cur_wait   <= cur_wait - CNT_W'(cur_wait != '0);
                            fresh      <= 1'b0;
                            state      <= SQ_END;
                        end else begin
                            state <= (cur_wait == '0) ? SQ_ISSUE : SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    if (tmr_last) state <= SQ_ISSUE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tester_checks.sv
module tester_checks #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_re,
    input logic              mem_rvalid,
    input logic              done,
    input logic              fail,
    input logic              best_valid
);
    logic outstanding;
    logic have_prev;
    logic prev_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            have_prev   <= 1'b0;
            prev_top    <= 1'b0;
        end else begin
            if (mem_re) outstanding <= 1'b1;
            else if (mem_rvalid) outstanding <= 1'b0;
            if (mem_we) begin
                have_prev <= 1'b0;
            end else if (mem_re) begin
                have_prev <= 1'b1;
                prev_top  <= mem_addr[ADDR_W-1];
            end
        end
    end

    a_r1_no_mixed_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r2_fill_pattern: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == {DATA_W{mem_addr[ADDR_W-1]}}));

    a_r3_half_toggle: assert property (@(posedge clk) disable iff (rst)
        (mem_re && have_prev) |-> (mem_addr[ADDR_W-1] != prev_top));

    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> !outstanding);

    a_r5_fail_with_done: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    a_r5_silent_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !(mem_re || mem_we));

    a_r6_pass_records: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !fail) |-> best_valid);
endmodule

bind split_speed_tester tester_checks #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .fail       (fail),
    .best_valid (best_valid)
);

// File: tb/split_speed_tester_tb.sv
module split_speed_tester_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 6;
    localparam int N      = 1 << ADDR_W;
    localparam int HALF   = N / 2;
    localparam int FAR    = 1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  wait_init = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_re;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_rvalid;
    logic              done;
    logic              fail;
    logic [ADDR_W-1:0] fail_addr;
    logic [CNT_W-1:0]  best_wait;
    logic              best_valid;

    split_speed_tester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .wait_init(wait_init),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .best_wait(best_wait), .best_valid(best_valid)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit wr;
        int addr;
        int data;
    } acc_t;

    acc_t exp_q[$];
    int   exp_gap = 0;
    int   slow_limit = 0;
    int   flip_addr = -1;
    int   gap_cnt;

    logic [DATA_W-1:0] mem [N];
    logic              s1_v;
    logic [DATA_W-1:0] s1_d;

    // Expected sweep state kept by the bench
    bit b_fresh = 1'b1;
    int b_wait = 0;
    int b_best = 0;
    bit b_best_valid = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Memory model: latency 2, corrupts reads that come too soon or hit flip_addr
    always @(posedge clk) begin
        if (rst) begin
            s1_v       <= 1'b0;
            s1_d       <= '0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            gap_cnt    <= FAR;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_we) gap_cnt <= FAR;
            else if (mem_rvalid) gap_cnt <= 0;
            else if (!mem_re && gap_cnt < FAR) gap_cnt <= gap_cnt + 1;
            s1_v <= mem_re;
            s1_d <= mem[mem_addr] ^
                    ((mem_re && (gap_cnt < slow_limit || int'(mem_addr) == flip_addr))
                     ? {DATA_W{1'b1}} : {DATA_W{1'b0}});
            mem_rvalid <= s1_v;
            mem_rdata  <= s1_d;
        end
    end

    // Monitor: pops expected accesses and compares
    always @(negedge clk) begin
        if (!rst && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected access addr", int'(mem_addr), -1);
            end else begin
                acc_t it;
                it = exp_q.pop_front();
                if (mem_we) begin
                    chk(it.wr, "R2", "write where read expected", 1, 0);
                    chk(int'(mem_addr) == it.addr, "R2", "fill address", int'(mem_addr), it.addr);
                    chk(int'(mem_wdata) == it.data, "R2", "fill data", int'(mem_wdata), it.data);
                end else begin
                    chk(!it.wr, "R3", "read where write expected", 1, 0);
                    chk(int'(mem_addr) == it.addr, "R3", "read order address", int'(mem_addr), it.addr);
                    if (gap_cnt < FAR)
                        chk(gap_cnt == exp_gap, "R4", "idle gap before read", gap_cnt, exp_gap);
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_pass(input bit poke);
        int  w;
        bit  pred_fail;
        int  pred_addr;
        int  n;
        acc_t it;
        if (b_fresh) begin
            b_wait = int'(wait_init);
            b_best_valid = 1'b0;
        end
        w = b_wait;
        exp_gap = w;
        for (int a = 0; a < N; a++) begin
            it.wr = 1'b1; it.addr = a; it.data = (a >= HALF) ? ((1 << DATA_W) - 1) : 0;
            exp_q.push_back(it);
        end
        pred_fail = 1'b0;
        pred_addr = 0;
        for (int j = 0; j < N; j++) begin
            int a;
            a = (j % 2) * HALF + j / 2;
            if (!pred_fail) begin
                it.wr = 1'b0; it.addr = a; it.data = 0;
                exp_q.push_back(it);
                if ((j > 0 && w < slow_limit) || a == flip_addr) begin
                    pred_fail = 1'b1;
                    pred_addr = a;
                end
            end
        end
        pulse_start();
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(!done, "R9", "done low mid-pass", int'(done), 0);
            pulse_start();   // R9: must be ignored
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R6", "pass reached done", int'(done), 1);
        chk(fail == pred_fail, pred_fail ? "R5" : "R6", "fail flag", int'(fail), int'(pred_fail));
        if (pred_fail) begin
            chk(int'(fail_addr) == pred_addr, "R5", "failing address", int'(fail_addr), pred_addr);
            b_fresh = 1'b1;
        end else begin
            b_best = w;
            b_best_valid = 1'b1;
            b_wait = (w > 0) ? w - 1 : 0;
            b_fresh = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "accesses left unissued", exp_q.size(), 0);
        exp_q.delete();
        chk(best_valid == b_best_valid, "R8", "best_valid", int'(best_valid), int'(b_best_valid));
        if (b_best_valid)
            chk(int'(best_wait) == b_best, "R6", "best_wait", int'(best_wait), b_best);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done, "R1", "done after reset", int'(done), 0);
        chk(!fail, "R1", "fail after reset", int'(fail), 0);
        chk(!mem_we, "R1", "mem_we after reset", int'(mem_we), 0);
        chk(!mem_re, "R1", "mem_re after reset", int'(mem_re), 0);
        chk(!best_valid, "R1", "best_valid after reset", int'(best_valid), 0);

        // Fresh sweep from 3: passes at 3, 2 (with busy start, R9), then 1 (R7)
        wait_init = CNT_W'(3);
        slow_limit = 0;
        flip_addr = -1;
        run_pass(1'b0);
        run_pass(1'b1);
        run_pass(1'b0);

        // Memory now needs at least one idle cycle: wait 0 fails at read of N/2 (R5)
        slow_limit = 1;
        run_pass(1'b0);

        // Restart after failure reloads wait_init (R8); corruption on the last read only
        slow_limit = 0;
        wait_init = CNT_W'(4);
        flip_addr = N - 1;
        run_pass(1'b0);

        // Saturation at zero (R7)
        flip_addr = -1;
        wait_init = CNT_W'(1);
        run_pass(1'b0);
        run_pass(1'b0);
        run_pass(1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule